// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns every cycle of a fast input clock into a thinned stream of single-cycle enable pulses. Downstream logic runs on the input clock and advances only on those enables. The thinning comes from a chain of two stages. The first stage either passes every cycle, keeps two cycles out of every three, or keeps one cycle out of every three. The second stage either passes the first stage's pulses or keeps every other one. The combined output rate is therefore 1, 2/3, 1/2, 1/3 or 1/6 of the input rate.

Software programs the block through a simple write port that addresses three byte-wide registers:

- **Mode register.** Holds a main-select bit. A write to this register briefly stretches the output.
- **Two divider control registers.** These choose the stage settings.

All registers come out of reset at zero. This enables every divider stage. Software is expected to set the main-select bit afterwards. While that bit is clear, an error flag stays raised.

New divider settings wait for the current output period to finish, so a change never produces a shortened pulse gap.

Top module: `frac_ce_div`

## Requirements
- R1: After synchronous reset, `ce_out` is 0. All three registers hold zero, so the output runs at 1/6 of the input rate: both first-stage reductions are selected, the one-in-three has priority, and the halving stage is on.
- R2: Bit 0 of the register at address 1 selects the two-in-three stage: 0 uses it and 1 bypasses it. With the halving stage bypassed, the output carries 8 enables in any 12 consecutive cycles. The stage's repeating pattern is drop, keep, keep.
- R3: Bit 1 of the register at address 1 selects the halving stage: 0 keeps every second first-stage pulse and 1 passes all of them. With a pass-through first stage, the output carries 6 enables per 12 cycles, and two enables are never adjacent.
- R4: Bit 0 of the register at address 2 selects the one-in-three stage: 0 uses it and 1 bypasses it. When it is used, it wins over the two-in-three selection, and the first stage keeps one cycle in three.
- R5: Over 12 input cycles, the enable counts are as follows:

| First stage | Second stage | Enables per 12 cycles |
|---|---|---|
| pass | pass | 12 |
| pass | halve | 6 |
| two-in-three | halve | 4 |
| one-in-three | pass | 4 |
| one-in-three | halve | 2 |

- R6: Any write to the mode register (address 0) suppresses exactly the two enables that would have appeared 2 and 3 cycles after the write cycle, and holds the divider phase. This happens even when the written value equals the stored one.
- R7: `sel_err` is high exactly while bit 0 of the mode register is 0. It changes on the cycle after the write. The bit does not alter the enable rate.
- R8: Bits other than those named in R2, R3, R4 and R7 are ignored on write.
- R9: A divider setting written while an output period is under way takes effect only after that period's enable. The new pattern then starts from its first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address: 0 mode, 1 divider A, 2 divider B |
| wr_data | input | 8 | Write data |
| ce_out | output | 1 | Registered clock-enable pulse train |
| sel_err | output | 1 | High while the main-select bit is 0 |

## Verification
A corrupted phase counter in either stage shows up as a wrong enable count within a single 12-cycle window, because 12 is a multiple of every period the block can produce. A shadow setting applied too early shows up in the first gap measured after the write: the old period's length is shortened, or the new pattern starts mid-phase. A stretch counter that loads or decrements wrongly changes how many enables vanish after a mode write, and this is visible within four cycles of that write.

// File: rtl/frac_ce_pkg.sv
package frac_ce_pkg;

    localparam int CE_ADDR_W = 2;
    localparam int CE_DATA_W = 8;

    // register addresses
    localparam int ADR_MODE = 0;
    localparam int ADR_DIVA = 1;
    localparam int ADR_DIVB = 2;

    // field positions
    localparam int BIT_MSEL   = 0;
    localparam int BIT_SKIP23 = 0;
    localparam int BIT_SKIP12 = 1;
    localparam int BIT_SKIP13 = 0;

    localparam int S1_PERIOD = 3;
    localparam int S1_PH_W   = $clog2(S1_PERIOD);

    typedef struct packed {
        logic skip13;
        logic skip23;
        logic skip12;
    } div_cfg_t;

    typedef enum logic [1:0] {
        S1_THIRD,
        S1_TWO_THIRDS,
        S1_PASS
    } s1_mode_e;

    function automatic s1_mode_e s1_mode_of(div_cfg_t c);
        if (!c.skip13)      return S1_THIRD;
        else if (!c.skip23) return S1_TWO_THIRDS;
        else                return S1_PASS;
    endfunction

    // phase 0 is the first cycle after a boundary
    function automatic logic s1_keep(s1_mode_e m, logic [S1_PH_W-1:0] ph);
        case (m)
            S1_THIRD:      return ph == S1_PH_W'(S1_PERIOD - 1);
            S1_TWO_THIRDS: return ph != '0;
            default:       return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/frac_ce_regs.sv
module frac_ce_regs
    import frac_ce_pkg::*;
#(
    parameter int AW = CE_ADDR_W,
    parameter int DW = CE_DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          out_pulse,
    output div_cfg_t      active_o,
    output logic          apply_o,
    output logic          msel_o,
    output logic          mode_wr_o
);

    div_cfg_t shadow_q, active_q;
    logic     pending_q, msel_q;
    logic     wr_mode, wr_a, wr_b, apply;

    assign wr_mode = wr_en && (wr_addr == AW'(ADR_MODE));
    assign wr_a    = wr_en && (wr_addr == AW'(ADR_DIVA));
    assign wr_b    = wr_en && (wr_addr == AW'(ADR_DIVB));
    assign apply   = pending_q && out_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= '0;
            active_q  <= '0;
            pending_q <= 1'b0;
            msel_q    <= 1'b0;
        end else begin
            if (wr_mode) msel_q <= wr_data[BIT_MSEL];
            if (wr_a) begin
                shadow_q.skip23 <= wr_data[BIT_SKIP23];
                shadow_q.skip12 <= wr_data[BIT_SKIP12];
            end
            if (wr_b) shadow_q.skip13 <= wr_data[BIT_SKIP13];
            pending_q <= (pending_q && !apply) || wr_a || wr_b;
            if (apply) active_q <= shadow_q;
        end
    end

    assign active_o  = active_q;
    assign apply_o   = apply;
    assign msel_o    = msel_q;
    assign mode_wr_o = wr_mode;

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_pulse |=> $stable(active_q));

endmodule

// File: rtl/frac_ce_stretch.sv
module frac_ce_stretch #(
    parameter int CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic step_o
);

    localparam int W = $clog2(CYC + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (trig)         cnt_q <= W'(CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign step_o = (cnt_q == '0);

    // R6
    stall_after_trig_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !step_o);

endmodule

// File: rtl/frac_ce_stage1.sv
module frac_ce_stage1
    import frac_ce_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  logic     restart,
    input  div_cfg_t cfg,
    output logic     p1_o
);

    logic [S1_PH_W-1:0] ph_q;
    s1_mode_e           mode;

    assign mode = s1_mode_of(cfg);
    assign p1_o = step && s1_keep(mode, ph_q);

    always_ff @(posedge clk) begin
        if (rst || restart) ph_q <= '0;
        else if (step)      ph_q <= (ph_q == S1_PH_W'(S1_PERIOD - 1)) ? '0 : ph_q + 1'b1;
    end

    // R4
    third_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == S1_THIRD) && p1_o && !restart |=> !p1_o);

endmodule

// File: rtl/frac_ce_stage2.sv
module frac_ce_stage2 (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic bypass,
    input  logic p1,
    output logic p2_o
);

    logic odd_q;

    assign p2_o = bypass ? p1 : (p1 && odd_q);

    always_ff @(posedge clk) begin
        if (rst || restart) odd_q <= 1'b0;
        else if (p1)        odd_q <= !odd_q;
    end

    // R3
    halve_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !bypass && p2_o && !restart |=> !p2_o);

endmodule

// File: rtl/frac_ce_div.sv
module frac_ce_div
    import frac_ce_pkg::*;
#(
    parameter int ADDR_W      = CE_ADDR_W,
    parameter int DATA_W      = CE_DATA_W,
    parameter int STRETCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ce_out,
    output logic              sel_err
);

    div_cfg_t cfg;
    logic     apply, msel, mode_wr, step, p1, p2, ce_q;

    frac_ce_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_pulse(p2), .active_o(cfg),
        .apply_o(apply), .msel_o(msel), .mode_wr_o(mode_wr)
    );

    frac_ce_stretch #(.CYC(STRETCH_CYC)) u_stretch (
        .clk(clk), .rst(rst), .trig(mode_wr), .step_o(step)
    );

    frac_ce_stage1 u_s1 (
        .clk(clk), .rst(rst), .step(step), .restart(apply),
        .cfg(cfg), .p1_o(p1)
    );

    frac_ce_stage2 u_s2 (
        .clk(clk), .rst(rst), .restart(apply), .bypass(cfg.skip12),
        .p1(p1), .p2_o(p2)
    );

    always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b0;
        else     ce_q <= p2;
    end

    assign ce_out  = ce_q;
    assign sel_err = !msel;

    // R6
    stretch_first_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> ##1 !ce_out);

    // R6
    stretch_second_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> ##2 !ce_out);

    // R7
    sel_err_track_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == ADDR_W'(ADR_MODE)) |=> sel_err == !$past(wr_data[BIT_MSEL]));

endmodule

// File: tb/test_frac_ce_div.sv
`timescale 1ns/1ps
module test_frac_ce_div;

    localparam real HALF = 4.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ce_out, sel_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #(HALF) clk = ~clk;

    frac_ce_div i_frac_ce_div (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ce_out(ce_out), .sel_err(sel_err)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // write starting at the current negedge
    task automatic wr_now(int a, int d);
        wr_en   = 1'b1;
        wr_addr = 2'(a);
        wr_data = 8'(d);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic set_div(int a, int b);
        wr(1, a);
        wr(2, b);
        repeat (12) @(negedge clk);
    endtask

    task automatic window(string tag, int exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        wait (exp_q.size() == 0);
    endtask

    // monitor: counts enables over 12 cycles per queued item
    initial begin
        forever begin
            int cnt;
            wait (exp_q.size() != 0);
            cnt = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (ce_out) cnt++;
            end
            chk(tag_q[0], cnt, exp_q[0]);
            void'(tag_q.pop_front());
            void'(exp_q.pop_front());
        end
    end

    initial begin
        #(HALF * 2.0 * 200000.0);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 ce_out after reset", int'(ce_out), 0);
        chk("R7 sel_err after reset", int'(sel_err), 1);
        // R1 R4: defaults give one-in-three (priority) and halving
        window("R1 default rate", 2);

        wr(0, 1);
        chk("R7 sel_err cleared", int'(sel_err), 0);

        set_div(3, 1); window("R5 pass/pass", 12);
        set_div(2, 1); window("R2 two-in-three", 8);
        set_div(1, 1); window("R3 halve", 6);
        set_div(0, 1); window("R2 R3 two-in-three halved", 4);
        set_div(3, 0); window("R4 one-in-three", 4);
        set_div(1, 0); window("R5 one-in-three halved", 2);
        set_div(2, 0); window("R4 priority over two-in-three", 4);
        set_div(0, 0); window("R4 priority halved", 2);
        set_div(8'hFF, 8'hFF); window("R8 upper bits set", 12);
        set_div(8'hFC, 8'hFE); window("R8 upper bits with zero fields", 2);

        // R6: stretch in pass mode
        set_div(3, 1);
        exp_q.push_back(10); tag_q.push_back("R6 stretch new value");
        repeat (3) @(negedge clk);
        wr_now(0, 0);
        wait (exp_q.size() == 0);
        chk("R7 sel_err set by zero", int'(sel_err), 1);

        exp_q.push_back(10); tag_q.push_back("R6 stretch");
        repeat (3) @(negedge clk);
        wr_now(0, 1);
        wait (exp_q.size() == 0);

        exp_q.push_back(10); tag_q.push_back("R6 stretch same value");
        repeat (3) @(negedge clk);
        wr_now(0, 1);
        wait (exp_q.size() == 0);
        chk("R7 sel_err after rewrite", int'(sel_err), 0);
        repeat (4) @(negedge clk);
        window("R7 rate unaffected", 12);

        // R9: change from 1/6 to 1/2 right after an enable
        set_div(1, 0);
        @(negedge clk);
        while (!ce_out) @(negedge clk);
        begin
            int g;
            wr_now(2, 1);
            g = 1;
            while (!ce_out) begin @(negedge clk); g++; end
            chk("R9 old period completes", g, 6);
            g = 0;
            do begin @(negedge clk); g++; end while (!ce_out);
            chk("R9 new period", g, 2);
        end

        finish_run();
    end

endmodule